// File: doc/BRIEF.md
# SRAM Low-Power Entry and Exit Sequencer

This block sits on the host side of one port of a synchronous SRAM. It owns the port's two chip-enable pins, its read/write pin and its sleep pin. A client issues single-cycle read or write accesses through a valid/ready handshake. The client can also ask the port to go to sleep or to wake up. The sequencer drives the pins so that every transition into and out of low-power mode is legal. It keeps the port deselected for a guard window before the sleep pin rises and for another guard window after it falls. It then holds one selected read-mode cycle before it hands the port back to the client.

While a transition is under way, the client is stalled: `accReady` is low and `busy` is high. A sleep request that arrives while an access is still in the memory pipeline waits until that access has drained. A wake request that arrives during sleep entry is remembered. The full entry runs to completion and the wake sequence starts straight after. All window lengths are parameters. Their defaults are three deselected cycles before sleep, three after wake, one settle cycle, and a two-cycle access pipeline.

Top module: `sram_sleep_seq`

## Requirements
- R1: After reset the port is deselected (`memCe0`=1, `memCe1`=0), `memRw`=1, `memZz`=0, `accReady`=1 and `busy`=0.
- R2: Selecting the port drives `memCe0`=0 with `memCe1`=1, and deselecting drives `memCe0`=1 with `memCe1`=0. The two pins are never equal. The sleep pin `memZz` is active high.
- R3: An access accepted on a clock edge (`accValid` and `accReady` both high) selects the port for exactly the following cycle, with `memRw`=0 for a write (`accWrite`=1) and `memRw`=1 for a read. When no access is accepted and the port is awake and idle, it stays deselected with `memRw`=1.
- R4: With no access in flight, a sleep request sampled on an edge drops `accReady` and raises `busy` after that edge. `memZz` rises on the fifth edge counted from that one. At least GUARD_PRE (3) deselected cycles with `memZz` low come before it.
- R5: A sleep request sampled on the same edge as an accepted access waits PIPE_LAT (2) further cycles for the access to drain. `memZz` then rises on the seventh edge counted from the request edge.
- R6: While `memZz` is high the port stays deselected, `accReady` stays low, and `accValid` has no effect on the pins.
- R7: A wake request sampled during sleep lowers `memZz` on that same edge. GUARD_POST (3) deselected cycles follow, then SETTLE_CYC (1) selected cycle with `memRw`=1. After that the port returns deselected with `accReady`=1 and `busy`=0.
- R8: `accReady` is high only when no transition is in progress and no sleep is pending, and `busy` is its complement.
- R9: A wake request received during the pre-sleep window does not cut the window short. `memZz` still rises on schedule, stays high for one cycle, and the wake sequence of R7 follows.
- R10: A wake request while awake, and a sleep request while asleep, are ignored: the pins and `accReady`/`busy` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Request to enter low-power mode |
| wakeReq | input | 1 | Request to leave low-power mode |
| accValid | input | 1 | Client access request |
| accWrite | input | 1 | Access is a write (1) or read (0) |
| accReady | output | 1 | Access accepted this cycle when high with accValid |
| busy | output | 1 | Transition in progress or sleep pending |
| memCe0 | output | 1 | Active-low chip enable to the SRAM |
| memCe1 | output | 1 | Active-high chip enable to the SRAM |
| memRw | output | 1 | Read (1) / write (0) select to the SRAM |
| memZz | output | 1 | Sleep pin to the SRAM, active high |

## Verification
The sleep path is driven in three patterns: from idle, together with a just-accepted access, and with a wake request landing inside the pre-sleep window. These give 5, 7 and 5 edges to sleep, which separates a correct drain from one that ignores the pipeline and from one that aborts entry early. Writes and reads are issued back to back so that a wrong or stuck read/write encoding shows at the pins. Requests the block must ignore are applied in the opposite power state, so that a block which honours them in the wrong state shows at the pins. The wake path is traced one cycle at a time, which exposes a short guard window or a settle cycle not in read mode.

// File: rtl/sram_sleep_pkg.sv
`timescale 1ns/1ps
package sram_sleep_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_PRE,
    ST_SLEEP,
    ST_POST,
    ST_SETTLE
  } seqState_t;

  typedef enum logic [1:0] {
    LD_PRE,
    LD_POST,
    LD_SETTLE
  } loadSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadCnt;
    loadSel_t loadSel;
    logic     accept;
    logic     acceptWrite;
    logic     pinSel;
    logic     pinZz;
  } seqStrobe_t;

endpackage

// File: rtl/sram_sleep_ctrl.sv
`timescale 1ns/1ps
module sram_sleep_ctrl
  import sram_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       cntZero,
  input  logic       flightZero,
  output logic       accReady,
  output logic       busy,
  output seqStrobe_t strobe
);

  seqState_t state, nextState;
  logic      sleepPend, wakePend;

  assign busy     = (state != ST_ACTIVE) || sleepPend;
  assign accReady = !busy;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_ACTIVE: if (sleepPend && flightZero) begin
        nextState      = ST_PRE;
        strobe.loadCnt = 1'b1;
        strobe.loadSel = LD_PRE;
      end
      ST_PRE: if (cntZero) nextState = ST_SLEEP;
      ST_SLEEP: if (wakePend || wakeReq) begin
        nextState      = ST_POST;
        strobe.loadCnt = 1'b1;
        strobe.loadSel = LD_POST;
      end
      ST_POST: if (cntZero) begin
        nextState      = ST_SETTLE;
        strobe.loadCnt = 1'b1;
        strobe.loadSel = LD_SETTLE;
      end
      ST_SETTLE: if (cntZero) nextState = ST_ACTIVE;
      default: nextState = ST_ACTIVE;
    endcase
    strobe.accept      = accValid && accReady;
    strobe.acceptWrite = accWrite;
    strobe.pinSel      = strobe.accept || (nextState == ST_SETTLE);
    strobe.pinZz       = (nextState == ST_SLEEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ACTIVE;
      sleepPend <= 1'b0;
      wakePend  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_ACTIVE) begin
        if (nextState == ST_PRE) sleepPend <= 1'b0;
        else if (sleepReq)       sleepPend <= 1'b1;
      end
      if (state == ST_SLEEP && nextState == ST_POST) wakePend <= 1'b0;
      else if ((state == ST_PRE || state == ST_SLEEP) && wakeReq) wakePend <= 1'b1;
    end
  end

  // R5
  drain_before_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && nextState == ST_PRE) |-> flightZero);

  // R9
  wake_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE && wakeReq) |=> (state == ST_PRE || state == ST_SLEEP));

  // R10
  wake_ignored_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !sleepPend && !sleepReq && wakeReq) |=> (state == ST_ACTIVE));

endmodule

// File: rtl/sram_sleep_dp.sv
`timescale 1ns/1ps
module sram_sleep_dp
  import sram_sleep_pkg::*;
#(
  parameter int GUARD_PRE  = 3,
  parameter int GUARD_POST = 3,
  parameter int SETTLE_CYC = 1,
  parameter int PIPE_LAT   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       cntZero,
  output logic       flightZero,
  output logic       memCe0,
  output logic       memCe1,
  output logic       memRw,
  output logic       memZz
);

  localparam int MAX_WIN = (GUARD_PRE > GUARD_POST) ?
                           ((GUARD_PRE > SETTLE_CYC) ? GUARD_PRE : SETTLE_CYC) :
                           ((GUARD_POST > SETTLE_CYC) ? GUARD_POST : SETTLE_CYC);
  localparam int CNT_W = $clog2(MAX_WIN + 1);
  localparam int FL_W  = $clog2(PIPE_LAT + 1);
  localparam int RUN_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] PRE_LOAD    = CNT_W'(GUARD_PRE - 1);
  localparam logic [CNT_W-1:0] POST_LOAD   = CNT_W'(GUARD_POST - 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [FL_W-1:0]  FL_LOAD     = FL_W'(PIPE_LAT);
  localparam logic [RUN_W-1:0] RUN_SAT     = RUN_W'(MAX_WIN);
  localparam logic [RUN_W-1:0] PRE_MIN     = RUN_W'(GUARD_PRE);
  localparam logic [RUN_W-1:0] POST_MIN    = RUN_W'(GUARD_POST);

  logic [CNT_W-1:0] winCnt;
  logic [FL_W-1:0]  flight;
  logic             selR, rwR, zzR;

  assign cntZero    = (winCnt == '0);
  assign flightZero = (flight == '0);
  assign memCe0     = !selR;
  assign memCe1     = selR;
  assign memRw      = rwR;
  assign memZz      = zzR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (strobe.loadCnt) begin
      unique case (strobe.loadSel)
        LD_PRE:    winCnt <= PRE_LOAD;
        LD_POST:   winCnt <= POST_LOAD;
        LD_SETTLE: winCnt <= SETTLE_LOAD;
        default:   winCnt <= '0;
      endcase
    end else if (!cntZero) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flight <= '0;
    else if (strobe.accept) flight <= FL_LOAD;
    else if (!flightZero)   flight <= flight - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selR <= 1'b0;
      rwR  <= 1'b1;
      zzR  <= 1'b0;
    end else begin
      selR <= strobe.pinSel;
      rwR  <= strobe.accept ? !strobe.acceptWrite : 1'b1;
      zzR  <= strobe.pinZz;
    end
  end

  // checker state: runs of quiet cycles around the sleep pin
  logic [RUN_W-1:0] deselRun, wakeRun;
  logic             zzPrev, waking;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deselRun <= '0;
      wakeRun  <= '0;
      zzPrev   <= 1'b0;
      waking   <= 1'b0;
    end else begin
      zzPrev <= zzR;
      if (!selR && !zzR) deselRun <= (deselRun == RUN_SAT) ? deselRun : deselRun + 1'b1;
      else               deselRun <= '0;
      if (zzR || selR)   wakeRun <= '0;
      else               wakeRun <= (wakeRun == RUN_SAT) ? wakeRun : wakeRun + 1'b1;
      if (zzR)           waking <= 1'b1;
      else if (selR)     waking <= 1'b0;
    end
  end

  // R4
  pre_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (zzR && !zzPrev) |-> (deselRun >= PRE_MIN));

  // R7
  post_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selR && waking) |-> (wakeRun >= POST_MIN && rwR));

  // R6
  zz_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    zzR |-> !selR);

  // R3
  access_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> (selR && (rwR == !$past(strobe.acceptWrite))));

endmodule

// File: rtl/sram_sleep_seq.sv
`timescale 1ns/1ps
module sram_sleep_seq #(
  parameter int GUARD_PRE  = 3,
  parameter int GUARD_POST = 3,
  parameter int SETTLE_CYC = 1,
  parameter int PIPE_LAT   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic wakeReq,
  input  logic accValid,
  input  logic accWrite,
  output logic accReady,
  output logic busy,
  output logic memCe0,
  output logic memCe1,
  output logic memRw,
  output logic memZz
);
  import sram_sleep_pkg::*;

  seqStrobe_t strobe;
  logic       cntZero, flightZero;

  sram_sleep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .accValid(accValid), .accWrite(accWrite), .cntZero(cntZero),
    .flightZero(flightZero), .accReady(accReady), .busy(busy), .strobe(strobe)
  );

  sram_sleep_dp #(
    .GUARD_PRE(GUARD_PRE), .GUARD_POST(GUARD_POST),
    .SETTLE_CYC(SETTLE_CYC), .PIPE_LAT(PIPE_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntZero(cntZero),
    .flightZero(flightZero), .memCe0(memCe0), .memCe1(memCe1),
    .memRw(memRw), .memZz(memZz)
  );

  // R2
  ce_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    memCe0 != memCe1);

  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    accReady != busy);

endmodule

// File: tb/sim_sram_sleep_seq.sv
`timescale 1ns/1ps
module sim_sram_sleep_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0, wakeReq = 1'b0, accValid = 1'b0, accWrite = 1'b0;
  logic accReady, busy, memCe0, memCe1, memRw, memZz;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  sram_sleep_seq u0 (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .accValid(accValid), .accWrite(accWrite), .accReady(accReady),
    .busy(busy), .memCe0(memCe0), .memCe1(memCe1), .memRw(memRw), .memZz(memZz)
  );

  // pins as {ce0, ce1, rw, zz}: idle 1010, asleep 1011, read 0110, write 0100
  logic [3:0] pins;
  assign pins = {memCe0, memCe1, memRw, memZz};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 pins", {4'b0, pins}, 8'h0A);
    check("R1 ready/busy", {6'b0, accReady, busy}, 8'h02);
  endtask

  task automatic t_access();
    accValid = 1'b1; accWrite = 1'b1;
    tick();
    check("R3 write pins", {4'b0, pins}, 8'h04);
    check("R2 select encoding", {6'b0, memCe0, memCe1}, 8'h01);
    accWrite = 1'b0;
    tick();
    check("R3 read pins", {4'b0, pins}, 8'h06);
    accValid = 1'b0;
    tick();
    check("R3 idle pins", {4'b0, pins}, 8'h0A);
    repeat (3) tick();
  endtask

  // counts edges from the request edge until memZz rises
  task automatic wait_zz(input string req, input int expEdges, input bit chkQuiet);
    int n = 1;
    while (!memZz && n < 20) begin
      if (chkQuiet) check({req, " quiet before sleep"}, {4'b0, pins}, 8'h0A);
      tick();
      n++;
    end
    check({req, " edges to sleep"}, 8'(n), 8'(expEdges));
    check({req, " asleep pins"}, {4'b0, pins}, 8'h0B);
  endtask

  task automatic t_sleep();
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    check("R4 stall after request", {6'b0, accReady, busy}, 8'h01);
    wait_zz("R4", 5, 1'b1);
    accValid = 1'b1; accWrite = 1'b1;
    tick();
    check("R6 access ignored asleep", {4'b0, pins}, 8'h0B);
    check("R6 ready low asleep", {7'b0, accReady}, 8'h00);
    accValid = 1'b0;
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    tick();
    check("R10 sleep ignored asleep", {4'b0, pins}, 8'h0B);
    check("R10 busy asleep", {6'b0, accReady, busy}, 8'h01);
  endtask

  task automatic t_wake(input string req);
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    check({req, " zz falls at once"}, {4'b0, pins}, 8'h0A);
    tick();
    check({req, " post guard 2"}, {4'b0, pins}, 8'h0A);
    tick();
    check({req, " post guard 3"}, {4'b0, pins}, 8'h0A);
    tick();
    check({req, " settle read select"}, {4'b0, pins}, 8'h06);
    check({req, " stalled in settle"}, {6'b0, accReady, busy}, 8'h01);
    tick();
    check({req, " back awake"}, {4'b0, pins}, 8'h0A);
    check({req, " R8 ready after wake"}, {6'b0, accReady, busy}, 8'h02);
  endtask

  task automatic t_inflight();
    accValid = 1'b1; accWrite = 1'b0; sleepReq = 1'b1;
    tick();
    accValid = 1'b0; sleepReq = 1'b0;
    check("R5 access issued", {4'b0, pins}, 8'h06);
    wait_zz("R5", 7, 1'b0);
  endtask

  task automatic t_wake_early();
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    tick();
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    check("R9 entry continues 3", {4'b0, pins}, 8'h0A);
    tick();
    check("R9 entry continues 4", {4'b0, pins}, 8'h0A);
    tick();
    check("R9 zz rises on schedule", {4'b0, pins}, 8'h0B);
    tick();
    check("R9 wake follows", {4'b0, pins}, 8'h0A);
    tick(); tick();
    check("R9 post guard", {4'b0, pins}, 8'h0A);
    tick();
    check("R9 settle", {4'b0, pins}, 8'h06);
    tick();
    check("R9 ready", {6'b0, accReady, busy}, 8'h02);
  endtask

  task automatic t_wake_awake();
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    check("R10 wake ignored awake pins", {4'b0, pins}, 8'h0A);
    check("R10 wake ignored awake ready", {6'b0, accReady, busy}, 8'h02);
    tick();
    check("R10 still awake", {4'b0, pins}, 8'h0A);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_access();
    t_wake_awake();
    t_sleep();
    t_wake("R7");
    t_inflight();
    t_wake("R7 after drain");
    t_wake_early();
    t_access();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end
endmodule